// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's store path and a slower memory write port. Stores are taken in at the rate the processor issues them and held in a small first-in first-out queue. They leave through a valid/ready drain port, one per handshake, in exactly the order they arrived. While a store waits in the queue, memory still holds an old value for that word.

A load probe lets the processor look up any word address in the same cycle. The lookup searches every queued entry. Each requested byte is taken from the newest queued store that writes that byte. The probe reports a hit only when every requested byte is supplied by the queue, so the load never sees stale memory data for bytes the queue owns.

The only back-pressure toward the processor is a full queue. A slow or stalled memory side does not block stores until all slots are taken.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty: `dr_valid` is 0, `st_ready` is 1 and `ld_hit` is 0.
- R2: Stores leave on the drain port in acceptance order, with address, data and byte enables unchanged. `dr_valid` is 1 exactly when at least one store is queued.
- R3: `st_ready` is 0 exactly when all DEPTH (default 4) slots are occupied. A store presented while `st_ready` is 0 is not queued and never appears on the drain port.
- R4: With `dr_ready` held at 0, DEPTH consecutive stores are each accepted on the cycle they are presented.
- R5: In a cycle where a store is accepted and a drain handshake completes, occupancy does not change.
- R6: The load probe is combinational. For each byte lane i (bits 8i+7:8i, lane i enabled by bit i of a byte-enable field) requested in `ld_be`, if a queued entry with the same word address enables lane i, `ld_data` carries that entry's byte. All other lanes of `ld_data` read 0. `ld_hit` is 1 when every requested lane is supplied.
- R7: When several queued entries supply the same requested lane, the byte comes from the most recently accepted one.
- R8: `ld_hit` is 0 when any requested lane is supplied by no entry, and also when `ld_be` is 0.
- R9: The entry being drained in the current cycle is still visible to the load probe in that cycle. A store accepted in the current cycle is visible from the next cycle.
- R10: A load whose word address matches no queued entry gives `ld_hit` 0 and `ld_data` 0.
- R11: While `dr_valid` is 1 and `dr_ready` is 0, the drain payload holds steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store slot available |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables, bit i for lane i |
| ld_addr | input | 32 | Load probe word address |
| ld_be | input | 4 | Load probe requested lanes |
| ld_hit | output | 1 | All requested lanes supplied by the queue |
| ld_data | output | 32 | Forwarded bytes, zero in unsupplied lanes |
| dr_valid | output | 1 | Oldest queued store offered to memory |
| dr_ready | input | 1 | Memory accepts the offered store |
| dr_addr | output | 32 | Drain word address |
| dr_data | output | 32 | Drain data |
| dr_be | output | 4 | Drain byte enables |

## Verification
The bench goes after lane merging across entries. A design that lets the oldest match win, or takes all four lanes from a single entry, returns a stale byte in one lane. It probes every requested-lane pattern against a known fill, so a hit flag built from "any lane covered" instead of "all lanes covered" reports false hits on partial coverage. Full-queue stores and store-plus-drain cycles are driven repeatedly: a miscounted occupancy either drops a store or lets a rejected one leak onto the drain port. Loads are also aimed at the entry leaving in the same cycle. A probe that masks the head early misses there.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int BE_W   = DATA_W / LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } sb_entry_t;

    // Overlay the enabled lanes of nval onto base.
    function automatic logic [DATA_W-1:0] lane_overlay(
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] nval,
        input logic [BE_W-1:0]   en
    );
        logic [DATA_W-1:0] res;
        res = base;
        for (int i = 0; i < BE_W; i++) begin
            if (en[i]) res[i*LANE_W +: LANE_W] = nval[i*LANE_W +: LANE_W];
        end
        return res;
    endfunction

    // Wrap an index sum back into [0, depth).
    function automatic int unsigned wrap_idx(input int unsigned v, input int unsigned depth);
        return (v >= depth) ? v - depth : v;
    endfunction

endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  sb_entry_t             push_entry,
    input  logic                  pop,
    output sb_entry_t             head,
    output logic                  full,
    output logic                  empty,
    output sb_entry_t [DEPTH-1:0] aged,      // index 0 is oldest
    output logic      [DEPTH-1:0] aged_vld
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_entry_t [DEPTH-1:0] slots;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] occ;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (occ == CNT_W'(DEPTH));
    assign empty = (occ == '0);
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_entry;
    end

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_age
            logic [PTR_W-1:0] slot_idx;
            assign slot_idx    = PTR_W'(wrap_idx(int'(rd_ptr) + k, DEPTH));
            assign aged[k]     = slots[slot_idx];
            assign aged_vld[k] = (CNT_W'(k) < occ);
        end
    endgenerate

endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  sb_entry_t [DEPTH-1:0] aged,
    input  logic      [DEPTH-1:0] aged_vld,
    input  logic [ADDR_W-1:0]     ld_addr,
    input  logic [BE_W-1:0]       ld_be,
    output logic                  ld_hit,
    output logic [DATA_W-1:0]     ld_data
);

    logic [DEPTH-1:0]  match;
    logic [BE_W-1:0]   covered;
    logic [DATA_W-1:0] merged;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
            assign match[k] = aged_vld[k] && (aged[k].addr == ld_addr);
        end
    endgenerate

    // Walk oldest to youngest so younger lanes overwrite older ones.
    always_comb begin
        covered = '0;
        merged  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match[k]) begin
                merged  = lane_overlay(merged, aged[k].data, aged[k].be & ld_be);
                covered = covered | (aged[k].be & ld_be);
            end
        end
    end

    assign ld_data = merged;
    assign ld_hit  = (ld_be != '0) && (covered == ld_be);

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BE_W-1:0]   ld_be,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              dr_valid,
    input  logic              dr_ready,
    output logic [ADDR_W-1:0] dr_addr,
    output logic [DATA_W-1:0] dr_data,
    output logic [BE_W-1:0]   dr_be
);

    sb_entry_t             in_entry, head;
    sb_entry_t [DEPTH-1:0] aged;
    logic      [DEPTH-1:0] aged_vld;
    logic                  full, empty, push, pop;

    assign in_entry = '{addr: st_addr, data: st_data, be: st_be};
    assign st_ready = !full;
    assign push     = st_valid && st_ready;
    assign dr_valid = !empty;
    assign pop      = dr_valid && dr_ready;
    assign dr_addr  = head.addr;
    assign dr_data  = head.data;
    assign dr_be    = head.be;

    sbuf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (in_entry),
        .pop        (pop),
        .head       (head),
        .full       (full),
        .empty      (empty),
        .aged       (aged),
        .aged_vld   (aged_vld)
    );

    sbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
        .aged     (aged),
        .aged_vld (aged_vld),
        .ld_addr  (ld_addr),
        .ld_be    (ld_be),
        .ld_hit   (ld_hit),
        .ld_data  (ld_data)
    );

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_ready,
    input logic              dr_valid,
    input logic              dr_ready,
    input logic [ADDR_W-1:0] dr_addr,
    input logic [DATA_W-1:0] dr_data,
    input logic [BE_W-1:0]   dr_be,
    input logic [BE_W-1:0]   ld_be,
    input logic              ld_hit
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    logic [CNT_W-1:0] shadow;

    // Occupancy counted from the handshakes alone.
    always_ff @(posedge clk) begin
        if (rst) shadow <= '0;
        else shadow <= shadow + CNT_W'(st_valid && st_ready) - CNT_W'(dr_valid && dr_ready);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_ready == (shadow < CNT_W'(DEPTH))); // R3

    AST_DRAIN_WHEN_QUEUED: assert property (@(posedge clk) disable iff (rst)
        dr_valid == (shadow != '0)); // R2

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data) && $stable(dr_be))); // R11

    AST_HIT_NEEDS_LANES: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> (ld_be != '0)); // R8

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !dr_valid |-> !ld_hit); // R10

    AST_SWAP_STEADY: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && dr_valid && dr_ready) |=> (st_ready && dr_valid)); // R5

endmodule

bind store_fwd_buffer sbuf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .dr_valid (dr_valid),
    .dr_ready (dr_ready),
    .dr_addr  (dr_addr),
    .dr_data  (dr_data),
    .dr_be    (dr_be),
    .ld_be    (ld_be),
    .ld_hit   (ld_hit)
);

// File: tb/store_fwd_buffer_tb.sv
module store_fwd_buffer_tb;

    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0, st_ready;
    logic [31:0] st_addr = '0, st_data = '0;
    logic [3:0]  st_be = '0;
    logic [31:0] ld_addr = '0;
    logic [3:0]  ld_be = '0;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic        dr_valid, dr_ready = 1'b0;
    logic [31:0] dr_addr, dr_data;
    logic [3:0]  dr_be;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference queue, index 0 oldest.
    logic [31:0] m_addr [D];
    logic [31:0] m_data [D];
    logic [3:0]  m_be   [D];
    int          m_cnt = 0;

    bit          prev_stall = 0;
    logic [67:0] prev_pay;

    always #4 clk = ~clk;

    store_fwd_buffer #(.DEPTH(D)) u_dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .ld_addr(ld_addr), .ld_be(ld_be), .ld_hit(ld_hit), .ld_data(ld_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready),
        .dr_addr(dr_addr), .dr_data(dr_data), .dr_be(dr_be)
    );

    task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at negedge with inputs set; checks outputs, then advances one edge.
    task automatic cycle(input bit drain_now);
        logic [31:0] e_data;
        logic [3:0]  cov;
        int          nm;
        bit          head_m, e_hit;
        string       tag;
        #1;
        chk(st_ready == (m_cnt < D), "R3 st_ready", {67'b0, st_ready}, {67'b0, (m_cnt < D)});
        chk(dr_valid == (m_cnt != 0), "R2 dr_valid", {67'b0, dr_valid}, {67'b0, (m_cnt != 0)});
        if (m_cnt != 0)
            chk({dr_addr, dr_data, dr_be} == {m_addr[0], m_data[0], m_be[0]}, "R2 drain payload",
                {dr_addr, dr_data, dr_be}, {m_addr[0], m_data[0], m_be[0]});
        if (prev_stall)
            chk({dr_addr, dr_data, dr_be} == prev_pay, "R11 payload held", {dr_addr, dr_data, dr_be}, prev_pay);
        e_data = '0; cov = '0; nm = 0; head_m = 0;
        for (int k = 0; k < m_cnt; k++) begin
            if (m_addr[k] == ld_addr && (m_be[k] & ld_be) != 0) begin
                nm++;
                if (k == 0) head_m = 1;
                for (int b = 0; b < 4; b++)
                    if (m_be[k][b] && ld_be[b]) e_data[b*8 +: 8] = m_data[k][b*8 +: 8];
                cov |= m_be[k] & ld_be;
            end
        end
        e_hit = (ld_be != 0) && (cov == ld_be);
        if (nm == 0) tag = "R10 no match";
        else if (!e_hit) tag = "R8 partial";
        else if (drain_now && head_m) tag = "R9 draining head";
        else if (nm > 1) tag = "R7 youngest wins";
        else tag = "R6 forward";
        chk({ld_hit, ld_data} == {e_hit, e_data}, tag, {35'b0, ld_hit, ld_data}, {35'b0, e_hit, e_data});
        prev_stall = (m_cnt != 0) && !dr_ready;
        prev_pay   = {dr_addr, dr_data, dr_be};
        @(posedge clk);
        begin
            bit sf, df;
            sf = st_valid && (m_cnt < D);
            df = dr_ready && (m_cnt != 0);
            if (df) begin
                for (int k = 0; k < D - 1; k++) begin
                    m_addr[k] = m_addr[k+1]; m_data[k] = m_data[k+1]; m_be[k] = m_be[k+1];
                end
                m_cnt--;
            end
            if (sf) begin
                m_addr[m_cnt] = st_addr; m_data[m_cnt] = st_data; m_be[m_cnt] = st_be;
                m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic set_store(input bit v, input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        st_valid = v; st_addr = a; st_data = d; st_be = b;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1;
        chk(!dr_valid && st_ready && !ld_hit, "R1 reset state",
            {65'b0, dr_valid, st_ready, ld_hit}, {65'b0, 1'b0, 1'b1, 1'b0});
        @(negedge clk);

        // R4 fill with memory stalled, each store accepted at once
        dr_ready = 0;
        for (int i = 0; i < D; i++) begin
            set_store(1, 32'h40, 32'h11223344 + i * 32'h01010101, 4'b0001 << i | (i == 3 ? 4'b0001 : 4'b0));
            #1 chk(st_ready, "R4 accept while stalled", {67'b0, st_ready}, 68'd1);
            #0;
            cycle(0);
        end
        // R3 store while full is ignored
        set_store(1, 32'h40, 32'hDEADBEEF, 4'hF);
        cycle(0); cycle(0);
        set_store(0, 0, 0, 0);

        // R6/R7/R8/R10 exhaustive probe sweep over lanes and addresses
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 16; b++) begin
                ld_addr = a ? 32'h41 : 32'h40; ld_be = 4'(b);
                cycle(0);
            end

        // R9 probe the head while it drains
        ld_addr = 32'h40; ld_be = 4'b0001; dr_ready = 1;
        cycle(1);
        // R5 store and drain together keep occupancy
        for (int i = 0; i < 6; i++) begin
            set_store(1, 32'h50 + i, 32'hA0A0A0A0 ^ i, 4'hF);
            cycle(1);
        end
        chk(dr_valid, "R5 occupancy kept", {67'b0, dr_valid}, 68'd1);
        set_store(0, 0, 0, 0); dr_ready = 0;
        // top up: exactly one slot free after three-deep swap
        set_store(1, 32'h60, 32'h5A5A5A5A, 4'hF);
        cycle(0);
        set_store(0, 0, 0, 0);
        #1 chk(!st_ready, "R5 full after one store", {67'b0, st_ready}, 68'd0);
        #0;
        cycle(0);

        // Randomized mix over a tiny address set
        for (int n = 0; n < 4000; n++) begin
            set_store($urandom_range(0, 1), 32'h70 + $urandom_range(0, 2), $urandom, 4'($urandom_range(0, 15)));
            dr_ready = ($urandom_range(0, 2) == 0);
            ld_addr  = 32'h70 + $urandom_range(0, 3);
            ld_be    = 4'($urandom_range(0, 15));
            cycle(dr_ready && m_cnt != 0);
        end

        // Drain out completely
        set_store(0, 0, 0, 0); dr_ready = 1;
        repeat (D + 1) cycle(1);
        #1 chk(!dr_valid && st_ready, "R2 drained empty", {66'b0, dr_valid, st_ready}, 68'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule